// File: doc/BRIEF.md
# Transmit Packet Framer

The framer assembles one radio packet and emits it as a serial bit stream for a modulator. The stream is one bit per clock with a valid strobe. A start strobe begins a packet from idle. The block first sends a configurable number of 0xAA preamble bytes and then a 16-bit sync word. After that it sends payload bytes taken one by one from a show-ahead transmit FIFO. If CRC is enabled, a 16-bit checksum follows the payload. Every byte leaves most-significant bit first, and there are no gaps between bits.

Payload length is set in one of two ways. In variable-length mode, the first FIFO byte holds a count L, and L further bytes follow it. That count includes an address byte if the receiver expects one. In fixed-length mode, the block reads exactly the number of FIFO bytes given in a configuration field, and any address byte is simply the first of them. A per-bit flag marks the bits that come after the sync word, so that a later whitening or FEC stage knows which bits it may process.

Suppose the FIFO is empty when a payload byte is due. The framer then stops the stream and latches an underflow state. Only the flush command clears that state. Refilling the FIFO does not clear it, and neither does a new start. A flush also cancels a packet in progress and returns the block to idle. A packet that completes produces a one-cycle done pulse. Configuration inputs must stay stable while a packet is in progress.

Top module: `tx_framer`

## Requirements
- R1: After start_i is taken in idle, the stream carries cfg_pre_len_i bytes of 0xAA, then cfg_sync_i[15:8], then cfg_sync_i[7:0], then the payload, then the optional CRC. Each byte is sent MSB first, one bit per clock, with bit_valid_o high on consecutive cycles from the first bit to the last.
- R2: With cfg_var_len_i=1, the first FIFO byte is sent and taken as a count L. Exactly L further FIFO bytes are then read and sent, for L+1 FIFO reads in total.
- R3: With cfg_var_len_i=0, exactly cfg_fix_len_i FIFO bytes are read and sent. An address byte, if used, is the first of these and needs no special handling.
- R4: With cfg_crc_en_i=1, the block sends a CRC-16 after the payload. The CRC uses polynomial 0x8005 with initial value 0xFFFF, has no reflection and no final XOR, and covers every byte read from the FIFO, including the length byte. The high byte goes first. With cfg_crc_en_i=0, no CRC bytes are sent.
- R5: whiten_o is 1 for every valid bit after the sync word, covering both payload and CRC. It is 0 for preamble and sync bits, and it is never 1 while bit_valid_o is 0.
- R6: If fifo_empty_i is 1 when a payload byte is due, the stream stops after the current byte, and underflow_o rises and stays at 1. While underflow_o is 1, no bits are sent and no FIFO reads occur, whether bytes are written to the FIFO or start_i is pulsed.
- R7: When flush_i is sampled high, then in the next cycle busy_o, bit_valid_o, underflow_o and done_o are all 0. A flush overrides a start or an underflow entry that falls in the same cycle.
- R8: done_o pulses for exactly one cycle, in the cycle right after the last valid bit of a completed packet, and busy_o is 0 from then on. Out of reset, every output is 0.
- R9: fifo_rd_o is asserted only while fifo_empty_i is 0. The FIFO is show-ahead, so fifo_data_i is the byte popped by fifo_rd_o. start_i has no effect while a packet is in progress.
- R10: cfg_pre_len_i=0 sends the sync word straight away. A variable-length count of 0 sends only the length byte, followed by the CRC when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a packet (accepted in idle only) |
| flush_i | input | 1 | Abort and return to idle, clears underflow |
| cfg_pre_len_i | input | PRE_W | Number of 0xAA preamble bytes |
| cfg_sync_i | input | 16 | Sync word, high byte sent first |
| cfg_var_len_i | input | 1 | 1: length byte leads payload; 0: fixed length |
| cfg_fix_len_i | input | 8 | FIFO byte count in fixed-length mode |
| cfg_crc_en_i | input | 1 | Append CRC-16 |
| fifo_data_i | input | 8 | Head byte of the transmit FIFO |
| fifo_empty_i | input | 1 | FIFO empty |
| fifo_rd_o | output | 1 | Pop the head byte |
| bit_o | output | 1 | Serial data bit |
| bit_valid_o | output | 1 | bit_o carries a packet bit |
| whiten_o | output | 1 | Current bit is after the sync word |
| busy_o | output | 1 | Packet in progress |
| underflow_o | output | 1 | Latched FIFO underflow |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
Underflow entry and flush can land in the same clock edge, and flush must win. To provoke this, the bench loads a variable-length packet whose FIFO holds fewer bytes than the count promises. It counts valid bits at the ports until the last bit of the final available byte is on the output, then raises flush_i for exactly the next edge, which is the edge at which the underflow would latch. After that edge, underflow_o and busy_o are expected low and stay low. A separate case pulses start_i in the middle of a packet and expects the bit stream to be identical to an undisturbed one.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;
  localparam int BYTE_W   = 8;
  localparam int CRC_W    = 16;
  localparam int CNT_W    = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
  localparam logic [BYTE_W-1:0] PRE_BYTE = 8'hAA;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_SYNC_H, S_SYNC_L, S_PAY, S_CRC_H, S_CRC_L, S_END, S_UFL
  } fr_state_e;

  // byte folded into the high half, then eight shift steps
  function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ {d, {(CRC_W-BYTE_W){1'b0}}};
    for (int i = 0; i < BYTE_W; i++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/tx_framer_crc.sv
module tx_framer_crc
  import tx_framer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_SEED;
    else if (init_i) crc_o <= CRC_SEED;
    else if (upd_i)  crc_o <= crc_next(crc_o, data_i);
  end
endmodule

// File: rtl/tx_framer_ser.sv
module tx_framer_ser #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] byte_i,
  input  logic         white_i,
  input  logic         stop_i,
  output logic         bit_o,
  output logic         vld_o,
  output logic         white_o,
  output logic         last_o
);
  localparam int IDX_W = $clog2(W);

  logic [W-1:0]     sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_q, wh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
      vld_q <= 1'b0;
      wh_q  <= 1'b0;
    end else if (load_i) begin
      sh_q  <= byte_i;
      idx_q <= '0;
      vld_q <= 1'b1;
      wh_q  <= white_i;
    end else if (stop_i) begin
      vld_q <= 1'b0;
      wh_q  <= 1'b0;
    end else if (vld_q) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o   = sh_q[W-1] & vld_q;
  assign vld_o   = vld_q;
  assign white_o = wh_q & vld_q;
  assign last_o  = vld_q && (idx_q == IDX_W'(W-1));
endmodule

// File: rtl/tx_framer_seq.sv
module tx_framer_seq
  import tx_framer_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              flush_i,
  input  logic [PRE_W-1:0]  cfg_pre_len_i,
  input  logic [15:0]       cfg_sync_i,
  input  logic              cfg_var_len_i,
  input  logic [CNT_W-1:0]  cfg_fix_len_i,
  input  logic              cfg_crc_en_i,
  input  logic [BYTE_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  input  logic              ser_vld_i,
  input  logic              ser_last_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              pop_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              white_o,
  output logic              stop_o,
  output logic              crc_init_o,
  output logic              crc_upd_o,
  output fr_state_e         state_o,
  output logic              done_o
);
  fr_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d, done_d, need;
  fr_state_e        st_after;

  assign need     = (st_q != S_IDLE) && (st_q != S_UFL) && (!ser_vld_i || ser_last_i);
  assign st_after = cfg_crc_en_i ? S_CRC_H : S_END;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; first_d = first_q; done_d = 1'b0;
    pop_o = 1'b0; load_o = 1'b0; byte_o = '0; white_o = 1'b0; stop_o = 1'b0;
    crc_init_o = 1'b0; crc_upd_o = 1'b0;
    if (flush_i) begin
      st_d   = S_IDLE;
      stop_o = 1'b1;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_d  = (cfg_pre_len_i == '0) ? S_SYNC_H : S_PRE;
          cnt_d = CNT_W'(cfg_pre_len_i);
        end
        S_PRE: if (need) begin
          load_o = 1'b1; byte_o = PRE_BYTE;
          cnt_d  = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_d = S_SYNC_H;
        end
        S_SYNC_H: if (need) begin
          load_o = 1'b1; byte_o = cfg_sync_i[15:8]; st_d = S_SYNC_L;
        end
        S_SYNC_L: if (need) begin
          load_o = 1'b1; byte_o = cfg_sync_i[7:0];
          crc_init_o = 1'b1;
          first_d = cfg_var_len_i;
          cnt_d   = cfg_fix_len_i;
          st_d    = (!cfg_var_len_i && cfg_fix_len_i == '0) ? st_after : S_PAY;
        end
        S_PAY: if (need) begin
          if (fifo_empty_i) begin
            st_d = S_UFL; stop_o = 1'b1;
          end else begin
            pop_o = 1'b1; load_o = 1'b1; byte_o = fifo_data_i;
            white_o = 1'b1; crc_upd_o = 1'b1;
            if (first_q) begin
              first_d = 1'b0;
              cnt_d   = fifo_data_i;
              if (fifo_data_i == '0) st_d = st_after;
            end else begin
              cnt_d = cnt_q - 1'b1;
              if (cnt_q == CNT_W'(1)) st_d = st_after;
            end
          end
        end
        S_CRC_H: if (need) begin
          load_o = 1'b1; byte_o = crc_i[15:8]; white_o = 1'b1; st_d = S_CRC_L;
        end
        S_CRC_L: if (need) begin
          load_o = 1'b1; byte_o = crc_i[7:0]; white_o = 1'b1; st_d = S_END;
        end
        S_END: if (need) begin
          stop_o = 1'b1; done_d = 1'b1; st_d = S_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; cnt_q <= '0; first_q <= 1'b0; done_o <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; first_q <= first_d; done_o <= done_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import tx_framer_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              flush_i,
  input  logic [PRE_W-1:0]  cfg_pre_len_i,
  input  logic [15:0]       cfg_sync_i,
  input  logic              cfg_var_len_i,
  input  logic [7:0]        cfg_fix_len_i,
  input  logic              cfg_crc_en_i,
  input  logic [7:0]        fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_rd_o,
  output logic              bit_o,
  output logic              bit_valid_o,
  output logic              whiten_o,
  output logic              busy_o,
  output logic              underflow_o,
  output logic              done_o
);
  logic              load, white, stop, crc_init, crc_upd, ser_vld, ser_last;
  logic [BYTE_W-1:0] byte_d;
  logic [CRC_W-1:0]  crc;
  fr_state_e         state;

  tx_framer_seq #(.PRE_W(PRE_W)) seq_i (
    .clk_i, .rst_ni, .start_i, .flush_i, .cfg_pre_len_i, .cfg_sync_i,
    .cfg_var_len_i, .cfg_fix_len_i, .cfg_crc_en_i, .fifo_data_i, .fifo_empty_i,
    .ser_vld_i(ser_vld), .ser_last_i(ser_last), .crc_i(crc),
    .pop_o(fifo_rd_o), .load_o(load), .byte_o(byte_d), .white_o(white),
    .stop_o(stop), .crc_init_o(crc_init), .crc_upd_o(crc_upd),
    .state_o(state), .done_o(done_o)
  );

  tx_framer_crc crc_i (
    .clk_i, .rst_ni, .init_i(crc_init), .upd_i(crc_upd), .data_i(byte_d), .crc_o(crc)
  );

  tx_framer_ser #(.W(BYTE_W)) ser_i (
    .clk_i, .rst_ni, .load_i(load), .byte_i(byte_d), .white_i(white), .stop_i(stop),
    .bit_o(bit_o), .vld_o(ser_vld), .white_o(whiten_o), .last_o(ser_last)
  );

  assign bit_valid_o = ser_vld;
  assign busy_o      = (state != S_IDLE) && (state != S_UFL);
  assign underflow_o = (state == S_UFL);
endmodule

// File: rtl/tx_framer_chk.sv
module tx_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic flush_i,
  input logic fifo_empty_i,
  input logic fifo_rd_o,
  input logic bit_valid_o,
  input logic whiten_o,
  input logic busy_o,
  input logic underflow_o,
  input logic done_o
);
  // R9
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i);
  // R6
  ufl_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !flush_i) |=> underflow_o);
  // R6
  ufl_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (!bit_valid_o && !fifo_rd_o));
  // R7
  flush_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!busy_o && !underflow_o && !bit_valid_o && !done_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !bit_valid_o && $past(bit_valid_o)));
  // R5
  whiten_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    whiten_o |-> bit_valid_o);
  // R1
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> busy_o);
endmodule

bind tx_framer tx_framer_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .fifo_empty_i(fifo_empty_i),
  .fifo_rd_o(fifo_rd_o), .bit_valid_o(bit_valid_o), .whiten_o(whiten_o),
  .busy_o(busy_o), .underflow_o(underflow_o), .done_o(done_o)
);

// File: tb/tx_framer_tb_top.sv
`timescale 1ns/1ps
module tx_framer_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, flush_i = 1'b0;
  logic [3:0]  cfg_pre_len_i = '0;
  logic [15:0] cfg_sync_i = '0;
  logic cfg_var_len_i = 1'b0, cfg_crc_en_i = 1'b0;
  logic [7:0] cfg_fix_len_i = '0;
  logic [7:0] fifo_data_i;
  logic fifo_empty_i, fifo_rd_o, bit_o, bit_valid_o, whiten_o, busy_o, underflow_o, done_o;

  always #4 clk_i = ~clk_i;

  tx_framer #(.PRE_W(4)) dut_i (.*);

  // bench FIFO, show-ahead
  logic [7:0] fmem [256];
  logic [7:0] rd_ptr = '0, wr_ptr = '0;
  assign fifo_empty_i = (rd_ptr == wr_ptr);
  assign fifo_data_i  = fmem[rd_ptr];
  always @(posedge clk_i) if (fifo_rd_o) rd_ptr <= rd_ptr + 8'd1;

  int n_chk = 0, n_err = 0;
  int cyc = 0, ncap = 0, ndone = 0, first_cyc = 0, last_cyc = 0, done_cyc = 0;
  logic cb [2048];
  logic cw [2048];
  logic eb [2048];
  logic ew [2048];
  int exp_n;
  logic [7:0] pl [64];

  always @(negedge clk_i) begin
    cyc++;
    if (bit_valid_o) begin
      if (ncap == 0) first_cyc = cyc;
      last_cyc = cyc;
      cb[ncap] = bit_o;
      cw[ncap] = whiten_o;
      ncap++;
    end
    if (done_o) begin
      ndone++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  task automatic push_exp(input logic [7:0] b, input logic w);
    for (int i = 7; i >= 0; i--) begin
      eb[exp_n] = b[i];
      ew[exp_n] = w;
      exp_n++;
    end
  endtask

  task automatic clear_cap();
    ncap = 0; ndone = 0; first_cyc = 0; last_cyc = 0; done_cyc = 0;
  endtask

  task automatic set_cfg(input int pre, input logic [15:0] sw, input logic vm,
                         input int fl, input logic ce);
    cfg_pre_len_i = 4'(pre); cfg_sync_i = sw; cfg_var_len_i = vm;
    cfg_fix_len_i = 8'(fl); cfg_crc_en_i = ce;
  endtask

  task automatic load_fifo(input int n);
    for (int i = 0; i < n; i++) begin
      fmem[wr_ptr] = pl[i];
      wr_ptr = wr_ptr + 8'd1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R8", "reset outputs", {28'd0, bit_valid_o, busy_o, underflow_o, done_o}, 0);
    chk("R9", "reset fifo_rd", int'(fifo_rd_o), 0);
  endtask

  task automatic run_packet(input string rq, input int pre, input logic [15:0] sw,
                            input logic vm, input int fl, input logic ce, input logic poke);
    int nf, t, bad_b, bad_w;
    logic [7:0] rd0;
    logic [15:0] c;
    @(negedge clk_i);
    set_cfg(pre, sw, vm, fl, ce);
    wr_ptr = rd_ptr; rd0 = rd_ptr;
    nf = vm ? int'(pl[0]) + 1 : fl;
    load_fifo(nf + 1);  // one spare byte must stay unread
    exp_n = 0;
    for (int i = 0; i < pre; i++) push_exp(8'hAA, 1'b0);
    push_exp(sw[15:8], 1'b0);
    push_exp(sw[7:0], 1'b0);
    c = 16'hFFFF;
    for (int i = 0; i < nf; i++) begin
      push_exp(pl[i], 1'b1);
      c = ref_crc(c, pl[i]);
    end
    if (ce) begin
      push_exp(c[15:8], 1'b1);
      push_exp(c[7:0], 1'b1);
    end
    clear_cap();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    t = 0;
    while (ndone == 0 && t < 3000) begin
      @(negedge clk_i);
      t++;
      start_i = (poke && t == 20);  // R9: start during a packet
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    bad_b = 0; bad_w = 0;
    for (int i = 0; i < exp_n && i < ncap; i++) begin
      if (cb[i] !== eb[i]) bad_b++;
      if (cw[i] !== ew[i]) bad_w++;
    end
    chk("R1", {rq, " bit count"}, ncap, exp_n);
    chk(rq, "bit mismatches", bad_b, 0);
    chk("R5", {rq, " whiten mismatches"}, bad_w, 0);
    chk("R1", {rq, " contiguous bits"}, last_cyc - first_cyc + 1, ncap);
    chk("R8", {rq, " done count"}, ndone, 1);
    chk("R8", {rq, " done timing"}, done_cyc, last_cyc + 1);
    chk(rq, "fifo reads", int'(8'(rd_ptr - rd0)), nf);
    chk("R8", {rq, " idle after"}, int'(busy_o), 0);
    wr_ptr = rd_ptr;
  endtask

  task automatic t_underflow();
    int t;
    logic [7:0] rd0;
    @(negedge clk_i);
    set_cfg(1, 16'h3C5A, 1'b1, 0, 1'b1);
    pl[0] = 8'd5; pl[1] = 8'h11; pl[2] = 8'h22;
    wr_ptr = rd_ptr; rd0 = rd_ptr;
    load_fifo(3);
    clear_cap();
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    t = 0;
    while (!underflow_o && t < 1000) begin @(negedge clk_i); t++; end
    chk("R6", "underflow set", int'(underflow_o), 1);
    chk("R6", "bits before stop", ncap, (1 + 2 + 3) * 8);
    chk("R6", "reads before stop", int'(8'(rd_ptr - rd0)), 3);
    chk("R6", "not busy in underflow", int'(busy_o), 0);
    for (int i = 0; i < 8; i++) pl[i] = 8'(i + 1);
    load_fifo(8);
    repeat (40) @(negedge clk_i);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk("R6", "still underflow after refill/start", int'(underflow_o), 1);
    chk("R6", "no bits after refill", ncap, 48);
    chk("R6", "no reads after refill", int'(8'(rd_ptr - rd0)), 3);
    chk("R8", "no done on underflow", ndone, 0);
    flush_i = 1'b1; @(negedge clk_i); flush_i = 1'b0;
    chk("R7", "flush clears underflow", int'(underflow_o), 0);
    chk("R7", "idle after flush", int'(busy_o), 0);
    wr_ptr = rd_ptr;
  endtask

  task automatic t_flush_mid();
    @(negedge clk_i);
    set_cfg(8, 16'h1234, 1'b0, 4, 1'b1);
    for (int i = 0; i < 5; i++) pl[i] = 8'hF0 + 8'(i);
    wr_ptr = rd_ptr;
    load_fifo(5);
    clear_cap();
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    repeat (30) @(negedge clk_i);
    chk("R7", "busy before flush", int'(busy_o), 1);
    flush_i = 1'b1; @(negedge clk_i); flush_i = 1'b0;
    chk("R7", "valid off after flush", int'(bit_valid_o), 0);
    chk("R7", "busy off after flush", int'(busy_o), 0);
    repeat (50) @(negedge clk_i);
    chk("R7", "no done after flush", ndone, 0);
    wr_ptr = rd_ptr;
  endtask

  // flush lands on the edge where underflow would latch
  task automatic t_flush_vs_ufl();
    int cnt, t;
    @(negedge clk_i);
    set_cfg(0, 16'hBEEF, 1'b1, 0, 1'b0);
    pl[0] = 8'd4; pl[1] = 8'h77;
    wr_ptr = rd_ptr;
    load_fifo(2);
    clear_cap();
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    cnt = 0; t = 0;
    while (cnt < 32 && t < 500) begin
      @(negedge clk_i); t++;
      if (bit_valid_o) cnt++;
    end
    flush_i = 1'b1; @(negedge clk_i); flush_i = 1'b0;
    chk("R7", "flush beats underflow", int'(underflow_o), 0);
    chk("R7", "idle after flush/underflow", int'(busy_o), 0);
    repeat (5) @(negedge clk_i);
    chk("R7", "underflow stays clear", int'(underflow_o), 0);
    wr_ptr = rd_ptr;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    // R2 + R4: variable length with CRC, start poked mid-packet
    pl[0] = 8'd3; pl[1] = 8'h5E; pl[2] = 8'h01; pl[3] = 8'hC3; pl[4] = 8'h99;
    run_packet("R2", 4, 16'hD391, 1'b1, 0, 1'b1, 1'b1);
    // R3: fixed length, first byte is address, no CRC
    pl[0] = 8'h42; pl[1] = 8'hDE; pl[2] = 8'hAD; pl[3] = 8'h00; pl[4] = 8'hFF; pl[5] = 8'h13;
    run_packet("R3", 2, 16'h7E81, 1'b0, 5, 1'b0, 1'b0);
    // R4: fixed length with CRC
    for (int i = 0; i < 10; i++) pl[i] = 8'(8'h31 + i);
    run_packet("R4", 3, 16'hA5A5, 1'b0, 9, 1'b1, 1'b0);
    // R10: no preamble, zero length byte, CRC on
    pl[0] = 8'd0; pl[1] = 8'hEE;
    run_packet("R10", 0, 16'h0F0F, 1'b1, 0, 1'b1, 1'b0);
    t_underflow();
    t_flush_mid();
    t_flush_vs_ufl();
    // ready for another packet after the aborts
    pl[0] = 8'd1; pl[1] = 8'h6B; pl[2] = 8'h00;
    run_packet("R2", 1, 16'hC0DE, 1'b1, 0, 1'b0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule